// File: doc/BRIEF.md
# DMA Block-Repeat Transfer Sequencer

This block keeps the running state of one DMA channel while it moves a block of data a programmed number of times. On the rising edge of the channel enable it captures the block byte count, the repeat count and the two start addresses, and it checks that the block size fits the configured data widths. After that, each pulse on the burst-done input reports how many bytes the data path has just moved. The sequencer then counts down the bytes left in the block and steps the source and destination addresses by their burst offsets.

When a block runs out of bytes, both addresses also move by a separate per-block offset, each in its own direction. The repeat counter then drops by one and the byte count reloads for the next block. When the final block completes, the linked-list control inputs decide what happens next. The block can ask for the next list item, restore both counts and stop, restore both counts and keep running, or leave everything at zero. Bus access, the data path and the fetching of list items are handled by neighbouring blocks.

Top module: `dma_blk_seq`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, the counts, addresses, active_o, blk_done_o, xfer_done_o, reload_req_o and cfg_err_o are all zero.
- R2: When en_i is high in a cycle and was low in the previous one, the following are loaded on that clock edge: bytes_left_o from cfg_bytes_i, rep_left_o from cfg_rep_i, src_addr_o from cfg_src_i and dst_addr_o from cfg_dst_i. The two counts are also kept as the programmed values. active_o is set only if cfg_bytes_i is non-zero and no setting error is raised. A zero block size gives active_o=0 and cfg_err_o=0.
- R3: Each accepted burst pulse (active_o=1, en_i=1, burst_done_i=1) lowers bytes_left_o by burst_bytes_i one cycle later. It also moves src_addr_o by src_off_i (added when src_dec_i=0, subtracted when 1) and dst_addr_o by dst_off_i under dst_dec_i. Addresses wrap modulo 2^32.
- R4: If burst_bytes_i is larger than bytes_left_o, the byte count stops at zero and the block completes.
- R5: When a burst empties the block, blk_done_o pulses for one cycle. In the same update, src_addr_o also moves by blk_src_off_i (sign from blk_src_dec_i, 1 = subtract) and dst_addr_o by blk_dst_off_i (sign from blk_dst_dec_i). If rep_left_o was non-zero, it drops by one and bytes_left_o reloads the programmed size.
- R6: When the block that empties has rep_left_o=0, xfer_done_o pulses together with blk_done_o.
- R7: At the end of a transfer with ll_upd_blk_i=1, reload_req_o pulses, both counts end at zero and active_o falls.
- R8: At the end of a transfer with ll_upd_blk_i=0 and ll_upd_other_i=1, both counts return to their programmed values and active_o falls.
- R9: At the end of a transfer with both update inputs 0 and ll_link_i non-zero, both counts return to their programmed values and active_o stays 1. The addresses keep moving from where they are.
- R10: At the end of a transfer with both update inputs 0 and ll_link_i zero, both counts stay zero and active_o falls.
- R11: Data width codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. A non-zero cfg_bytes_i that is not a multiple of the source width sets cfg_err_o on the enable edge and keeps active_o low.
- R12: When pack_i=1 and src_dw_i differs from dst_dw_i, a non-zero cfg_bytes_i must also be a multiple of the destination width. Otherwise cfg_err_o is set and active_o stays low. With pack_i=0 the destination width is not checked.
- R13: While active_o is low, burst pulses change neither the counts nor the addresses. Dropping en_i clears active_o and holds all state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable; its rising edge starts a transfer |
| cfg_bytes_i | input | 16 | Programmed block size in bytes |
| cfg_rep_i | input | 11 | Programmed number of extra blocks |
| cfg_src_i | input | 32 | Source start address |
| cfg_dst_i | input | 32 | Destination start address |
| src_off_i | input | 16 | Source offset applied after each burst |
| dst_off_i | input | 16 | Destination offset applied after each burst |
| src_dec_i | input | 1 | 1 = subtract src_off_i |
| dst_dec_i | input | 1 | 1 = subtract dst_off_i |
| blk_src_off_i | input | 16 | Source offset applied at block end |
| blk_dst_off_i | input | 16 | Destination offset applied at block end |
| blk_src_dec_i | input | 1 | 1 = subtract blk_src_off_i |
| blk_dst_dec_i | input | 1 | 1 = subtract blk_dst_off_i |
| src_dw_i | input | 2 | Source width code (bytes = 2^code) |
| dst_dw_i | input | 2 | Destination width code |
| pack_i | input | 1 | Packing mode |
| ll_upd_blk_i | input | 1 | List item updates the block register |
| ll_upd_other_i | input | 1 | OR of all other list update bits |
| ll_link_i | input | 16 | Link address of the next list item |
| burst_done_i | input | 1 | One pulse per completed burst |
| burst_bytes_i | input | 16 | Bytes moved by that burst |
| bytes_left_o | output | 16 | Bytes remaining in the current block |
| rep_left_o | output | 11 | Blocks remaining after the current one |
| src_addr_o | output | 32 | Current source address |
| dst_addr_o | output | 32 | Current destination address |
| active_o | output | 1 | Channel is counting |
| blk_done_o | output | 1 | Block completed (one cycle) |
| xfer_done_o | output | 1 | Transfer completed (one cycle) |
| reload_req_o | output | 1 | Request for the next list item (one cycle) |
| cfg_err_o | output | 1 | Setting error from the last enable |

## Verification
The bench aims at the block boundary, where a design that drops the block offset or gets its sign wrong leaves an address off by exactly the block step. It also covers the four end-of-transfer policies, since a wrong priority between the block-update bit, the other update bits and the link address gives the wrong counts or a wrong active_o. An oversized burst tests saturation: a design without it wraps the byte count to a large value and never ends the block. A source address just below 2^32 shows whether the address wraps. Width and packing errors are tested on both sides of the rule, and bursts are sent while the channel is in error. A design that still counts would move the addresses there.

// File: rtl/dma_blk_pkg.sv
package dma_blk_pkg;
  typedef enum logic [1:0] {
    END_FETCH    = 2'd0,
    END_RESTORE  = 2'd1,
    END_CONTINUE = 2'd2,
    END_ZERO     = 2'd3
  } end_act_e;

  // byte mask for an alignment check of 2^code bytes
  function automatic logic [2:0] width_mask(input logic [1:0] code);
    case (code)
      2'd0:    width_mask = 3'b000;
      2'd1:    width_mask = 3'b001;
      2'd2:    width_mask = 3'b011;
      default: width_mask = 3'b111;
    endcase
  endfunction
endpackage

// File: rtl/dma_cfg_chk.sv
module dma_cfg_chk #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] bytes_i,
  input  logic [1:0]       src_dw_i,
  input  logic [1:0]       dst_dw_i,
  input  logic             pack_i,
  output logic             err_o
);
  import dma_blk_pkg::*;

  logic nonzero;
  logic src_bad;
  logic dst_bad;

  always_comb begin
    nonzero = |bytes_i;
    src_bad = |(bytes_i[2:0] & width_mask(src_dw_i));
    dst_bad = pack_i && (src_dw_i != dst_dw_i) && (|(bytes_i[2:0] & width_mask(dst_dw_i)));
    err_o   = nonzero && (src_bad || dst_bad);
  end
endmodule

// File: rtl/dma_end_policy.sv
module dma_end_policy #(
  parameter int LINK_W = 16
) (
  input  logic              upd_blk_i,
  input  logic              upd_other_i,
  input  logic [LINK_W-1:0] link_i,
  output dma_blk_pkg::end_act_e act_o
);
  import dma_blk_pkg::*;

  always_comb begin
    if (upd_blk_i)        act_o = END_FETCH;
    else if (upd_other_i) act_o = END_RESTORE;
    else if (|link_i)     act_o = END_CONTINUE;
    else                  act_o = END_ZERO;
  end
endmodule

// File: rtl/dma_addr_unit.sv
module dma_addr_unit #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int BOFF_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              step_i,
  input  logic              blk_end_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              dec_i,
  input  logic [BOFF_W-1:0] blk_off_i,
  input  logic              blk_dec_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] burst_delta;
  logic [ADDR_W-1:0] blk_delta;
  logic [ADDR_W-1:0] off_ext;
  logic [ADDR_W-1:0] blk_ext;
  logic [ADDR_W-1:0] addr_q;

  always_comb begin
    off_ext     = {{(ADDR_W-OFF_W){1'b0}}, off_i};
    blk_ext     = blk_end_i ? {{(ADDR_W-BOFF_W){1'b0}}, blk_off_i} : '0;
    // two's complement negation gives modulo-2^ADDR_W subtraction
    burst_delta = dec_i     ? (~off_ext + 1'b1) : off_ext;
    blk_delta   = blk_dec_i ? (~blk_ext + 1'b1) : blk_ext;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (load_i)  addr_q <= load_addr_i;
    else if (step_i)  addr_q <= addr_q + burst_delta + blk_delta;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/dma_blk_seq.sv
module dma_blk_seq #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int REP_W  = 11,
  parameter int OFF_W  = 16,
  parameter int BOFF_W = 16,
  parameter int LINK_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [CNT_W-1:0]  cfg_bytes_i,
  input  logic [REP_W-1:0]  cfg_rep_i,
  input  logic [ADDR_W-1:0] cfg_src_i,
  input  logic [ADDR_W-1:0] cfg_dst_i,
  input  logic [OFF_W-1:0]  src_off_i,
  input  logic [OFF_W-1:0]  dst_off_i,
  input  logic              src_dec_i,
  input  logic              dst_dec_i,
  input  logic [BOFF_W-1:0] blk_src_off_i,
  input  logic [BOFF_W-1:0] blk_dst_off_i,
  input  logic              blk_src_dec_i,
  input  logic              blk_dst_dec_i,
  input  logic [1:0]        src_dw_i,
  input  logic [1:0]        dst_dw_i,
  input  logic              pack_i,
  input  logic              ll_upd_blk_i,
  input  logic              ll_upd_other_i,
  input  logic [LINK_W-1:0] ll_link_i,
  input  logic              burst_done_i,
  input  logic [CNT_W-1:0]  burst_bytes_i,
  output logic [CNT_W-1:0]  bytes_left_o,
  output logic [REP_W-1:0]  rep_left_o,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic [ADDR_W-1:0] dst_addr_o,
  output logic              active_o,
  output logic              blk_done_o,
  output logic              xfer_done_o,
  output logic              reload_req_o,
  output logic              cfg_err_o
);
  import dma_blk_pkg::*;

  localparam int NCH = 2;  // 0 = source, 1 = destination
  localparam logic [REP_W-1:0] REP_ONE = {{(REP_W-1){1'b0}}, 1'b1};

  logic              en_q;
  logic              active_q;
  logic              err_q;
  logic              blk_done_q;
  logic              xfer_done_q;
  logic              reload_q;
  logic [CNT_W-1:0]  bytes_q;
  logic [REP_W-1:0]  rep_q;
  logic [CNT_W-1:0]  sh_bytes_q;
  logic [REP_W-1:0]  sh_rep_q;

  logic              start;
  logic              step;
  logic              blk_end;
  logic [CNT_W-1:0]  take;
  logic [CNT_W-1:0]  bytes_rem;
  logic              set_err;
  end_act_e          end_act;

  logic [NCH-1:0][ADDR_W-1:0] ld_addr;
  logic [NCH-1:0][OFF_W-1:0]  b_off;
  logic [NCH-1:0][BOFF_W-1:0] k_off;
  logic [NCH-1:0]             b_dec;
  logic [NCH-1:0]             k_dec;
  logic [NCH-1:0][ADDR_W-1:0] cur_addr;

  dma_cfg_chk #(.CNT_W(CNT_W)) i_cfg_chk (
    .bytes_i  (cfg_bytes_i),
    .src_dw_i (src_dw_i),
    .dst_dw_i (dst_dw_i),
    .pack_i   (pack_i),
    .err_o    (set_err)
  );

  dma_end_policy #(.LINK_W(LINK_W)) i_end_policy (
    .upd_blk_i   (ll_upd_blk_i),
    .upd_other_i (ll_upd_other_i),
    .link_i      (ll_link_i),
    .act_o       (end_act)
  );

  always_comb begin
    start     = en_i && !en_q;
    step      = active_q && en_i && burst_done_i;
    take      = (burst_bytes_i > bytes_q) ? bytes_q : burst_bytes_i;
    bytes_rem = bytes_q - take;
    blk_end   = step && (bytes_rem == '0);
  end

  assign ld_addr = {cfg_dst_i, cfg_src_i};
  assign b_off   = {dst_off_i, src_off_i};
  assign k_off   = {blk_dst_off_i, blk_src_off_i};
  assign b_dec   = {dst_dec_i, src_dec_i};
  assign k_dec   = {blk_dst_dec_i, blk_src_dec_i};

  for (genvar g = 0; g < NCH; g++) begin : g_addr
    dma_addr_unit #(
      .ADDR_W (ADDR_W),
      .OFF_W  (OFF_W),
      .BOFF_W (BOFF_W)
    ) i_addr (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (start),
      .load_addr_i (ld_addr[g]),
      .step_i      (step),
      .blk_end_i   (blk_end),
      .off_i       (b_off[g]),
      .dec_i       (b_dec[g]),
      .blk_off_i   (k_off[g]),
      .blk_dec_i   (k_dec[g]),
      .addr_o      (cur_addr[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q        <= 1'b0;
      active_q    <= 1'b0;
      err_q       <= 1'b0;
      blk_done_q  <= 1'b0;
      xfer_done_q <= 1'b0;
      reload_q    <= 1'b0;
      bytes_q     <= '0;
      rep_q       <= '0;
      sh_bytes_q  <= '0;
      sh_rep_q    <= '0;
    end else begin
      en_q        <= en_i;
      blk_done_q  <= 1'b0;
      xfer_done_q <= 1'b0;
      reload_q    <= 1'b0;
      if (start) begin
        bytes_q    <= cfg_bytes_i;
        rep_q      <= cfg_rep_i;
        sh_bytes_q <= cfg_bytes_i;
        sh_rep_q   <= cfg_rep_i;
        err_q      <= set_err;
        active_q   <= !set_err && (cfg_bytes_i != '0);
      end else if (!en_i) begin
        active_q <= 1'b0;
      end else if (step) begin
        blk_done_q <= blk_end;
        if (!blk_end) begin
          bytes_q <= bytes_rem;
        end else if (rep_q != '0) begin
          rep_q   <= rep_q - REP_ONE;
          bytes_q <= sh_bytes_q;
        end else begin
          xfer_done_q <= 1'b1;
          case (end_act)
            END_FETCH: begin
              bytes_q  <= '0;
              reload_q <= 1'b1;
              active_q <= 1'b0;
            end
            END_RESTORE: begin
              bytes_q  <= sh_bytes_q;
              rep_q    <= sh_rep_q;
              active_q <= 1'b0;
            end
            END_CONTINUE: begin
              bytes_q  <= sh_bytes_q;
              rep_q    <= sh_rep_q;
            end
            default: begin
              bytes_q  <= '0;
              active_q <= 1'b0;
            end
          endcase
        end
      end
    end
  end

  assign bytes_left_o = bytes_q;
  assign rep_left_o   = rep_q;
  assign src_addr_o   = cur_addr[0];
  assign dst_addr_o   = cur_addr[1];
  assign active_o     = active_q;
  assign blk_done_o   = blk_done_q;
  assign xfer_done_o  = xfer_done_q;
  assign reload_req_o = reload_q;
  assign cfg_err_o    = err_q;
endmodule

// File: rtl/dma_blk_seq_chk.sv
module dma_blk_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int REP_W  = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              burst_done_i,
  input logic [CNT_W-1:0]  burst_bytes_i,
  input logic [CNT_W-1:0]  bytes_left_o,
  input logic [REP_W-1:0]  rep_left_o,
  input logic [ADDR_W-1:0] src_addr_o,
  input logic [ADDR_W-1:0] dst_addr_o,
  input logic              active_o,
  input logic              blk_done_o,
  input logic              xfer_done_o,
  input logic              reload_req_o,
  input logic              cfg_err_o
);
  p_err_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !active_o);

  p_xfer_with_blk_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_o |-> blk_done_o);

  p_byte_dec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && en_i && burst_done_i && (burst_bytes_i < bytes_left_o))
    |=> (bytes_left_o == CNT_W'($past(bytes_left_o) - $past(burst_bytes_i))));

  p_rep_dec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && en_i && burst_done_i && (burst_bytes_i >= bytes_left_o) && (rep_left_o != '0))
    |=> (blk_done_o && (rep_left_o == REP_W'($past(rep_left_o) - 1'b1))));

  p_reload_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_req_o |-> (bytes_left_o == '0 && rep_left_o == '0 && !active_o && xfer_done_o));

  p_idle_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && !en_i) |=> ($stable(src_addr_o) && $stable(dst_addr_o)
                             && $stable(bytes_left_o) && $stable(rep_left_o)));
endmodule

bind dma_blk_seq dma_blk_seq_chk #(
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W),
  .REP_W  (REP_W)
) i_dma_blk_seq_chk (.*);

// File: tb/test_dma_blk_seq.sv
module test_dma_blk_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [15:0] cfg_bytes_i = '0;
  logic [10:0] cfg_rep_i = '0;
  logic [31:0] cfg_src_i = '0;
  logic [31:0] cfg_dst_i = '0;
  logic [15:0] src_off_i = '0;
  logic [15:0] dst_off_i = '0;
  logic        src_dec_i = 1'b0;
  logic        dst_dec_i = 1'b0;
  logic [15:0] blk_src_off_i = '0;
  logic [15:0] blk_dst_off_i = '0;
  logic        blk_src_dec_i = 1'b0;
  logic        blk_dst_dec_i = 1'b0;
  logic [1:0]  src_dw_i = '0;
  logic [1:0]  dst_dw_i = '0;
  logic        pack_i = 1'b0;
  logic        ll_upd_blk_i = 1'b0;
  logic        ll_upd_other_i = 1'b0;
  logic [15:0] ll_link_i = '0;
  logic        burst_done_i = 1'b0;
  logic [15:0] burst_bytes_i = '0;
  logic [15:0] bytes_left_o;
  logic [10:0] rep_left_o;
  logic [31:0] src_addr_o;
  logic [31:0] dst_addr_o;
  logic        active_o;
  logic        blk_done_o;
  logic        xfer_done_o;
  logic        reload_req_o;
  logic        cfg_err_o;

  always #5 clk_i = ~clk_i;

  dma_blk_seq i_dma_blk_seq (.*);

  typedef struct {
    logic [15:0] bytes;
    logic [10:0] rep;
    logic [31:0] src;
    logic [31:0] dst;
    logic        act;
    logic        blk;
    logic        xfer;
    logic        rr;
    logic        err;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_run = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;

  // reference state
  logic [15:0] m_bytes = '0, m_sh_bytes = '0;
  logic [10:0] m_rep = '0, m_sh_rep = '0;
  logic [31:0] m_src = '0, m_dst = '0;
  logic        m_act = 0, m_blk = 0, m_xfer = 0, m_rr = 0, m_err = 0;

  task automatic push_exp(input string tag);
    exp_t e;
    e.bytes = m_bytes; e.rep = m_rep; e.src = m_src; e.dst = m_dst;
    e.act = m_act; e.blk = m_blk; e.xfer = m_xfer; e.rr = m_rr; e.err = m_err;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  function automatic logic [31:0] mv(input logic [31:0] a, input logic [15:0] off, input logic dec);
    return dec ? a - {16'h0, off} : a + {16'h0, off};
  endfunction

  task automatic enable(input logic [15:0] bytes, input logic [10:0] rep,
                        input logic [31:0] src, input logic [31:0] dst, input string tag);
    logic [2:0] smask, dmask;
    @(negedge clk_i);
    cfg_bytes_i = bytes; cfg_rep_i = rep; cfg_src_i = src; cfg_dst_i = dst;
    en_i = 1'b1;
    smask = 3'((4'd1 << src_dw_i) - 1);
    dmask = 3'((4'd1 << dst_dw_i) - 1);
    m_err = (bytes != 0) && (((bytes[2:0] & smask) != 0) ||
            (pack_i && (src_dw_i != dst_dw_i) && ((bytes[2:0] & dmask) != 0)));
    m_act = !m_err && (bytes != 0);
    m_bytes = bytes; m_rep = rep; m_sh_bytes = bytes; m_sh_rep = rep;
    m_src = src; m_dst = dst;
    m_blk = 0; m_xfer = 0; m_rr = 0;
    push_exp(tag);
  endtask

  task automatic disable_ch();
    @(negedge clk_i);
    en_i = 1'b0;
    m_act = 0;
    @(negedge clk_i);
  endtask

  task automatic burst(input logic [15:0] n, input string tag);
    logic [15:0] tk;
    @(negedge clk_i);
    burst_done_i = 1'b1; burst_bytes_i = n;
    m_blk = 0; m_xfer = 0; m_rr = 0;
    if (m_act) begin
      tk = (n > m_bytes) ? m_bytes : n;
      m_bytes = m_bytes - tk;
      m_src = mv(m_src, src_off_i, src_dec_i);
      m_dst = mv(m_dst, dst_off_i, dst_dec_i);
      if (m_bytes == 0) begin
        m_blk = 1;
        m_src = mv(m_src, blk_src_off_i, blk_src_dec_i);
        m_dst = mv(m_dst, blk_dst_off_i, blk_dst_dec_i);
        if (m_rep != 0) begin
          m_rep = m_rep - 1; m_bytes = m_sh_bytes;
        end else begin
          m_xfer = 1;
          if (ll_upd_blk_i) begin m_rr = 1; m_act = 0; end
          else if (ll_upd_other_i) begin m_bytes = m_sh_bytes; m_rep = m_sh_rep; m_act = 0; end
          else if (ll_link_i != 0) begin m_bytes = m_sh_bytes; m_rep = m_sh_rep; end
          else m_act = 0;
        end
      end
    end
    push_exp(tag);
    @(negedge clk_i);
    burst_done_i = 1'b0;
    m_blk = 0; m_xfer = 0; m_rr = 0;
  endtask

  // monitor: compares one expected item per clock edge after the edge settles
  initial begin
    forever begin
      @(posedge clk_i);
      if (exp_q.size() > 0) begin
        exp_t e;
        #1;
        e = exp_q.pop_front();
        n_run++;
        if (bytes_left_o !== e.bytes || rep_left_o !== e.rep || src_addr_o !== e.src ||
            dst_addr_o !== e.dst || active_o !== e.act || blk_done_o !== e.blk ||
            xfer_done_o !== e.xfer || reload_req_o !== e.rr || cfg_err_o !== e.err) begin
          n_fail++;
          $display("FAIL %s: act bytes=%0d rep=%0d src=%h dst=%h a=%b b=%b x=%b r=%b e=%b | exp bytes=%0d rep=%0d src=%h dst=%h a=%b b=%b x=%b r=%b e=%b",
                   e.tag, bytes_left_o, rep_left_o, src_addr_o, dst_addr_o, active_o,
                   blk_done_o, xfer_done_o, reload_req_o, cfg_err_o,
                   e.bytes, e.rep, e.src, e.dst, e.act, e.blk, e.xfer, e.rr, e.err);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    n_run++;
    if (bytes_left_o !== 0 || rep_left_o !== 0 || src_addr_o !== 0 || dst_addr_o !== 0 ||
        active_o !== 0 || blk_done_o !== 0 || xfer_done_o !== 0 || reload_req_o !== 0 ||
        cfg_err_o !== 0) begin
      n_fail++;
      $display("FAIL R1 in reset: act bytes=%0d src=%h act=%b exp all zero", bytes_left_o, src_addr_o, active_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    push_exp("R1 after reset");
    @(negedge clk_i);

    // R2/R3/R5/R6/R10: three blocks, all list bits clear
    src_dw_i = 2; dst_dw_i = 2;
    src_off_i = 4; src_dec_i = 0; dst_off_i = 8; dst_dec_i = 1;
    blk_src_off_i = 16'h100; blk_src_dec_i = 0; blk_dst_off_i = 16'h40; blk_dst_dec_i = 1;
    enable(16, 2, 32'h1000, 32'h2000, "R2 load");
    for (int i = 0; i < 6; i++) burst(8, "R3 R5 R6 R10 repeat blocks");
    burst(8, "R13 burst after end ignored");
    disable_ch();

    // R4/R7: oversized burst saturates, block-update bit requests reload
    src_dw_i = 0; dst_dw_i = 0; ll_upd_blk_i = 1; ll_upd_other_i = 1; ll_link_i = 16'h10;
    enable(12, 0, 32'h0, 32'h80, "R2 load");
    burst(8, "R4 partial");
    burst(8, "R4 R7 saturate and fetch");
    disable_ch();

    // R8: other update bits restore counts and stop
    ll_upd_blk_i = 0; ll_upd_other_i = 1;
    enable(4, 1, 32'h300, 32'h400, "R2 load");
    burst(4, "R8 first block");
    burst(4, "R8 restore stop");
    burst(4, "R13 idle after restore");
    disable_ch();

    // R9: continuous with source address wrap
    ll_upd_other_i = 0; ll_link_i = 16'h20;
    src_off_i = 8; blk_src_off_i = 4; blk_src_dec_i = 1;
    enable(8, 0, 32'hFFFF_FFF8, 32'h10, "R2 load");
    burst(8, "R9 R3 wrap continue");
    burst(3, "R9 keeps counting");
    burst(5, "R9 second loop");
    disable_ch();
    burst(4, "R13 disabled");

    // R11: source width error
    ll_link_i = 0; src_dw_i = 2; dst_dw_i = 2;
    enable(6, 0, 32'h500, 32'h600, "R11 width error");
    burst(2, "R13 ignored in error");
    disable_ch();

    // R12: packing error, then same sizes without packing
    src_dw_i = 1; dst_dw_i = 3; pack_i = 1;
    enable(4, 0, 32'h700, 32'h800, "R12 packing error");
    disable_ch();
    pack_i = 0;
    enable(4, 0, 32'h700, 32'h800, "R12 no packing accepted");
    burst(4, "R12 R10 runs to end");
    disable_ch();

    // R2: zero block size
    enable(0, 3, 32'h900, 32'hA00, "R2 zero size idle");
    burst(4, "R13 zero size ignores burst");
    disable_ch();

    repeat (3) @(negedge clk_i);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule